// File: doc/BRIEF.md
# Vocoder Parameter Frame SPI Master

This block is an SPI master that moves one fixed-length parameter frame at a time between a host and an external voice-codec device. A frame always has the same shape: a command byte, then an address byte of zero, then exactly 27 payload bytes. The command byte picks the direction. 0x83 reads and 0x03 writes.

The host starts a frame with a one-cycle `start` pulse and picks the direction with `start_write`. On a write, the block asks for each payload byte through a ready/valid handshake just before it shifts that byte out. If the byte is late, it parks the serial clock low until the byte arrives. On a read, every received payload byte comes out with a one-cycle strobe and its position in the frame.

The serial clock is derived from the system clock by a half-period divider parameter. The default of 16 system clocks per half period gives 3.90625 MHz from a 125 MHz clock, which stays below the 4 MHz limit of the codec link. Only one frame runs at a time. `busy` and `done` tell the host when the link is free again.

Top module: `vspi_frame_master`

## Requirements
- R1: A read frame (`start_write`=0) shifts out 0x83, then 0x00, then 27 bytes of 0x00 (MOSI held low through the read payload).
- R2: A write frame (`start_write`=1) shifts out 0x03, then 0x00, then the 27 bytes accepted on `wr_data`, in the order they were accepted.
- R3: Transfers use SPI mode 0, MSB first. SCLK idles low. MOSI changes only while SCLK is low and stays stable while SCLK is high. MISO is sampled on each rising SCLK edge.
- R4: Every SCLK high phase lasts exactly HALF_DIV system clocks. Every SCLK low phase inside a frame also lasts HALF_DIV clocks, except where a write stall stretches it.
- R5: `cs_n` falls HALF_DIV clocks before the first rising SCLK edge and stays low for all 232 rising edges of the frame. It rises HALF_DIV clocks after the final falling edge. SCLK is low whenever `cs_n` is high.
- R6: On a write, `wr_ready` is high while the block waits for the next payload byte. A byte is taken in the cycle where both `wr_valid` and `wr_ready` are high. SCLK stays low for as long as the byte is withheld.
- R7: On a read, each of the 27 payload bytes is presented on `rd_data` with a one-cycle `rd_valid` pulse and `rd_index` counting 0 to 26 in order. The bytes clocked in during the command and address bytes produce no strobe.
- R8: `done` is a one-cycle pulse in the first cycle that `cs_n` is high again. `busy` is high from the cycle after the accepted `start` through the `done` cycle, and low in the cycle after.
- R9: A `start` pulse while `busy` is high is ignored. The running frame keeps its direction and length, and no second frame follows it.
- R10: MOSI is low whenever `cs_n` is high, and low between the last write payload bit and the rise of `cs_n`.
- R11: While reset is asserted: `cs_n`=1, `sclk`=0, `mosi`=0, and `busy`, `done`, `wr_ready` and `rd_valid` are all 0. A reset in the middle of a frame aborts that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run a frame; taken only when idle |
| start_write | input | 1 | Direction with `start`: 1 write, 0 read |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | `wr_data` holds the next payload byte |
| wr_ready | output | 1 | Block waits for the next write payload byte |
| rd_data | output | 8 | Received read payload byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` / `rd_index` |
| rd_index | output | IDX_W | Payload byte position, 0 to NUM_DATA-1 |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the codec |
| miso | input | 1 | Serial data from the codec |

## Verification
The hardest situation to reach from the ports is a write whose payload byte arrives late. The block must then park SCLK low in the middle of a frame and resume without losing or repeating a bit. The bench holds `wr_valid` low for a set number of cycles after each `wr_ready`. During that window it checks that SCLK never rises, and afterwards it checks that the byte stream the device model captured is still exact. A second hard case is a request that arrives mid-frame with the opposite direction. The bench injects one partway through a read and confirms that the command byte, the count of received strobes and the idle period after `done` are all unchanged.

// File: rtl/vspi_pkg.sv
package vspi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_FETCH = 3'd3,
    ST_TAIL  = 3'd4,
    ST_DONE  = 3'd5
  } vspi_state_e;

  localparam logic [7:0] VSPI_OP_READ  = 8'h83;
  localparam logic [7:0] VSPI_OP_WRITE = 8'h03;
  localparam logic [7:0] VSPI_ADDR     = 8'h00;

  function automatic logic [7:0] vspi_opcode(input logic is_write);
    return is_write ? VSPI_OP_WRITE : VSPI_OP_READ;
  endfunction

endpackage

// File: rtl/vspi_rst_sync.sv
module vspi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vspi_halfper.sv
module vspi_halfper #(
  parameter int HALF_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == '0);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = RELOAD;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/vspi_shift.sv
module vspi_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  input  logic       tx_shift,
  input  logic       rx_shift,
  input  logic       miso,
  output logic       tx_msb,
  output logic [7:0] rx_byte
);

  logic [7:0] tx_q, tx_d;
  logic [7:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (tx_load)       tx_d = tx_byte;
    else if (tx_shift) tx_d = {tx_q[6:0], 1'b0};
    rx_d = rx_q;
    if (rx_shift)      rx_d = {rx_q[6:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_load || tx_shift) tx_q <= tx_d;
      if (rx_shift)            rx_q <= rx_d;
    end
  end

  assign tx_msb  = tx_q[7];
  assign rx_byte = rx_q;

endmodule

// File: rtl/vspi_ctrl.sv
module vspi_ctrl
  import vspi_pkg::*;
#(
  parameter int NUM_DATA = 27,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic             tick,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rx_byte,
  output logic             run,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  output logic             tx_shift,
  output logic             rx_shift,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi_en,
  output logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_index
);

  localparam int FRAME_BYTES = NUM_DATA + 2;
  localparam int BW = $clog2(FRAME_BYTES);
  localparam logic [BW-1:0] LAST_BYTE  = BW'(FRAME_BYTES - 1);
  localparam logic [BW-1:0] FIRST_DATA = BW'(2);

  vspi_state_e state_q, state_d;
  logic [2:0]       bit_q, bit_d;
  logic [BW-1:0]    byte_q, byte_d;
  logic             wr_q, wr_d;
  logic             rdv_q, rdv_d;
  logic [7:0]       rdd_q, rdd_d;
  logic [IDX_W-1:0] rdi_q, rdi_d;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    wr_d     = wr_q;
    rdv_d    = 1'b0;
    rdd_d    = rdd_q;
    rdi_d    = rdi_q;
    tx_load  = 1'b0;
    tx_byte  = 8'h00;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          wr_d    = start_write;
          bit_d   = '0;
          byte_d  = '0;
          tx_load = 1'b1;
          tx_byte = vspi_opcode(start_write);
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tick) begin
          rx_shift = 1'b1;
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          if (bit_q != 3'd7) begin
            bit_d    = bit_q + 3'd1;
            tx_shift = 1'b1;
            state_d  = ST_LOW;
          end else begin
            bit_d = '0;
            if (!wr_q && (byte_q >= FIRST_DATA)) begin
              rdv_d = 1'b1;
              rdd_d = rx_byte;
              rdi_d = IDX_W'(byte_q - FIRST_DATA);
            end
            if (byte_q == LAST_BYTE) begin
              tx_load = 1'b1;
              tx_byte = 8'h00;
              state_d = ST_TAIL;
            end else begin
              byte_d  = byte_q + 1'b1;
              tx_load = 1'b1;
              if (byte_q == '0) begin
                tx_byte = VSPI_ADDR;
                state_d = ST_LOW;
              end else if (wr_q) begin
                tx_byte = 8'h00;
                state_d = ST_FETCH;
              end else begin
                tx_byte = 8'h00;
                state_d = ST_LOW;
              end
            end
          end
        end
      end
      ST_FETCH: begin
        if (wr_valid) begin
          tx_load = 1'b1;
          tx_byte = wr_data;
          state_d = ST_LOW;
        end
      end
      ST_TAIL: begin
        if (tick) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      wr_q    <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      rdi_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      wr_q    <= wr_d;
      rdv_q   <= rdv_d;
      if (rdv_d) begin
        rdd_q <= rdd_d;
        rdi_q <= rdi_d;
      end
    end
  end

  assign run      = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TAIL);
  assign sclk     = (state_q == ST_HIGH);
  assign cs_n     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign mosi_en  = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign wr_ready = (state_q == ST_FETCH);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
  assign rd_index = rdi_q;

endmodule

// File: rtl/vspi_frame_master.sv
module vspi_frame_master #(
  parameter  int HALF_DIV = 16,
  parameter  int NUM_DATA = 27,
  localparam int IDX_W    = $clog2(NUM_DATA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic [IDX_W-1:0] rd_index,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  logic       rst_n_i;
  logic       run, tick;
  logic       tx_load, tx_shift, rx_shift, tx_msb, mosi_en;
  logic [7:0] tx_byte, rx_byte;

  vspi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  vspi_halfper #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (run),
    .tick  (tick)
  );

  vspi_shift u_sh (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .tx_shift (tx_shift),
    .rx_shift (rx_shift),
    .miso     (miso),
    .tx_msb   (tx_msb),
    .rx_byte  (rx_byte)
  );

  vspi_ctrl #(.NUM_DATA(NUM_DATA), .IDX_W(IDX_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .start       (start),
    .start_write (start_write),
    .tick        (tick),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .rx_byte     (rx_byte),
    .run         (run),
    .tx_load     (tx_load),
    .tx_byte     (tx_byte),
    .tx_shift    (tx_shift),
    .rx_shift    (rx_shift),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .mosi_en     (mosi_en),
    .wr_ready    (wr_ready),
    .busy        (busy),
    .done        (done),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_index    (rd_index)
  );

  assign mosi = mosi_en & tx_msb;

endmodule

// File: rtl/vspi_frame_checker.sv
module vspi_frame_checker #(
  parameter  int HALF_DIV = 16,
  parameter  int NUM_DATA = 27,
  localparam int IDX_W    = $clog2(NUM_DATA)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             cs_n,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic             wr_ready,
  input logic             wr_valid,
  input logic             rd_valid,
  input logic [IDX_W-1:0] rd_index
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + 16'd1;
    else           hi_cnt <= '0;
  end

  p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == 16'(HALF_DIV)));

  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> !sclk && wr_ready);

  p_rd_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_index < IDX_W'(NUM_DATA)));

  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_done_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && busy);

  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  p_mosi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

endmodule

bind vspi_frame_master vspi_frame_checker #(
  .HALF_DIV (HALF_DIV),
  .NUM_DATA (NUM_DATA)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .mosi     (mosi),
  .busy     (busy),
  .done     (done),
  .wr_ready (wr_ready),
  .wr_valid (wr_valid),
  .rd_valid (rd_valid),
  .rd_index (rd_index)
);

// File: tb/sim_vspi_frame_master.sv
`timescale 1ns/1ps
module sim_vspi_frame_master;

  localparam int HALF   = 16;
  localparam int NDATA  = 27;
  localparam int NBYTES = NDATA + 2;
  localparam int NRISE  = NBYTES * 8;

  // vector: [15] write, [14:8] stall cycles per payload byte, [7:0] seed
  localparam logic [15:0] VEC [6] = '{16'h0000, 16'h805A, 16'h00C3,
                                      16'hA811, 16'h83FF, 16'h007E};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, start_write = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_valid = 1'b0;
  logic       miso = 1'b0;
  logic       wr_ready, rd_valid, busy, done, sclk, cs_n, mosi;
  logic [7:0] rd_data;
  logic [4:0] rd_index;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  vspi_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_index(rd_index),
    .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] wr_byte(input logic [7:0] s, input int i);
    return s ^ 8'(i * 37 + 1);
  endfunction

  function automatic logic [7:0] sl_byte(input logic [7:0] s, input int k);
    return 8'(int'(s) + k * 53) ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model and monitor, all at the falling system-clock edge
  logic [7:0] cur_seed = 8'h00;
  bit         cur_write = 1'b0;
  logic [7:0] cap [NBYTES];
  logic [7:0] sh = 8'h00;
  int  cyc = 0, rise_cnt = 0, bit_pos = 0, byte_pos = 0;
  int  t_csfall = 0, t_rise = 0, t_fall = 0, lead = 0, tail = 0;
  int  rd_cnt = 0;
  bit  prev_sclk = 1'b0, prev_cs = 1'b1;
  bit  hi_bad = 0, lo_bad = 0, rd_err = 0, tail_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      t_csfall = cyc; rise_cnt = 0; bit_pos = 0; byte_pos = 0;
      miso = sl_byte(cur_seed, 0)[7];
    end
    if (!cs_n && !sclk && rise_cnt == NRISE && mosi) tail_bad = 1;
    if (!prev_sclk && sclk) begin
      if (rise_cnt == 0) lead = cyc - t_csfall;
      else if (!cur_write && (cyc - t_fall) != HALF) lo_bad = 1;
      t_rise = cyc;
      rise_cnt++;
      sh = {sh[6:0], mosi};
      bit_pos++;
      if (bit_pos == 8) begin
        if (byte_pos < NBYTES) cap[byte_pos] = sh;
        byte_pos++;
        bit_pos = 0;
      end
    end
    if (prev_sclk && !sclk) begin
      if ((cyc - t_rise) != HALF) hi_bad = 1;
      t_fall = cyc;
      if (byte_pos < NBYTES) miso = sl_byte(cur_seed, byte_pos)[7 - bit_pos];
    end
    if (!prev_cs && cs_n) tail = cyc - t_fall;
    if (rd_valid) begin
      if (int'(rd_index) != rd_cnt || rd_data != sl_byte(cur_seed, rd_cnt + 2)) rd_err = 1;
      rd_cnt++;
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  task automatic run_frame(input bit wr, input int stall, input logic [7:0] seed,
                           input bit restart);
    int  widx = 0, stall_ctr = 0, n = 0;
    bit  stall_bad = 0, busy_bad = 0, got_done = 0;
    cur_seed = seed; cur_write = wr;
    hi_bad = 0; lo_bad = 0; rd_err = 0; tail_bad = 0; rd_cnt = 0;
    @(negedge clk); start = 1'b1; start_write = wr;
    @(negedge clk); start = 1'b0;
    while (!got_done && n < 20000) begin
      n++;
      if (restart && n == 500) begin start = 1'b1; start_write = !wr; end
      if (restart && n == 501) start = 1'b0;
      if (done) got_done = 1;
      else if (!busy) busy_bad = 1;
      if (wr_valid) begin wr_valid = 1'b0; widx++; stall_ctr = 0; end
      if (wr_ready && !wr_valid) begin
        if (stall_ctr < stall) begin
          stall_ctr++;
          if (sclk) stall_bad = 1;
        end else begin
          wr_data = wr_byte(seed, widx);
          wr_valid = 1'b1;
        end
      end
      if (!got_done) @(negedge clk);
    end
    check(got_done, "R8", "frame ends with done", got_done, 1);
    check(cs_n == 1'b1, "R8", "cs_n high in done cycle", cs_n, 1);
    check(!busy_bad, "R8", "busy held until done", busy_bad, 0);
    @(negedge clk);
    check(!done && !busy, "R8", "done single cycle, busy dropped", {done, busy}, 0);
    check(cap[0] == (wr ? 8'h03 : 8'h83), wr ? "R2" : "R1", "command byte (R3 MSB first)",
          cap[0], wr ? 8'h03 : 8'h83);
    check(cap[1] == 8'h00, wr ? "R2" : "R1", "address byte", cap[1], 0);
    begin
      int bad = -1;
      for (int i = 0; i < NDATA; i++)
        if (cap[i + 2] != (wr ? wr_byte(seed, i) : 8'h00) && bad < 0) bad = i;
      check(bad < 0, wr ? "R2" : "R1", "payload bytes on MOSI", bad, -1);
    end
    check(rise_cnt == NRISE, "R5", "rising edges in frame", rise_cnt, NRISE);
    check(lead == HALF, "R5", "cs_n lead to first rise", lead, HALF);
    check(tail == HALF, "R5", "last fall to cs_n rise", tail, HALF);
    check(!hi_bad && !lo_bad, "R4", "SCLK half period", {hi_bad, lo_bad}, 0);
    check(!tail_bad, "R10", "MOSI low after last bit", tail_bad, 0);
    if (wr) begin
      check(widx == NDATA, "R6", "payload bytes accepted", widx, NDATA);
      check(!stall_bad, "R6", "SCLK held low during stall", stall_bad, 0);
      check(rd_cnt == 0, "R7", "no read strobes on write", rd_cnt, 0);
    end else begin
      check(rd_cnt == NDATA, "R7", "read strobes (cmd/addr discarded)", rd_cnt, NDATA);
      check(!rd_err, "R7", "read data/index (R3 MISO at rise)", rd_err, 0);
    end
  endtask

  initial begin
    #(8 * 195000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !mosi && !busy && !done && !wr_ready && !rd_valid, "R11",
          "reset outputs", {cs_n, sclk, mosi, busy, done, wr_ready, rd_valid}, 7'b1000000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][15], int'(VEC[v][14:8]), VEC[v][7:0], 1'b0);

    // R9: request of opposite direction during a read frame
    run_frame(1'b0, 0, 8'h3C, 1'b1);
    repeat (50) @(negedge clk);
    check(cs_n && !busy, "R9", "no second frame after ignored start", {cs_n, busy}, 2'b10);

    // R11: reset in the middle of a write frame
    cur_write = 1'b1;
    @(negedge clk); start = 1'b1; start_write = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    wr_valid = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !mosi && !busy && !done && !wr_ready && !rd_valid, "R11",
          "mid-frame reset outputs", {cs_n, sclk, mosi, busy, done, wr_ready, rd_valid},
          7'b1000000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_frame(1'b1, 2, 8'h96, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule